// File: doc/BRIEF.md
# NAND Prefetch and Post-Write FIFO Engine

This block sits between a host bus and a byte-wide NAND data stream and buffers a whole transfer through a 64-byte FIFO. The host programs a length, a direction and a DMA flag and pulses a start command. In prefetch direction the engine pulls bytes from the NAND stream and the host drains them as 32-bit words. In post-write direction the host pushes 16-bit words and the engine feeds them byte by byte to the NAND stream. A single 32-bit status word gives the FIFO count in bits 30:24 and the bytes still outstanding in bits 13:0. The FIFO count is the filled bytes when prefetching and the free bytes when post-writing.

The controller is a four-state machine: `ST_IDLE`, `ST_FETCH`, `ST_POST` and `ST_DONE`. The transitions are as follows:
- An accepted start moves `ST_IDLE` to `ST_FETCH` (prefetch) or `ST_POST` (post-write), or straight to `ST_DONE` when the effective length is zero.
- `ST_FETCH` moves to `ST_DONE` when the last byte is taken from NAND.
- `ST_POST` moves to `ST_DONE` when the last byte is handed to NAND.
- `ST_DONE` is held until a reset command.
- A reset command returns any state to `ST_IDLE` and empties the FIFO.

A start seen in any state other than `ST_IDLE` is refused. The DMA request is a level that marks one full 64-byte frame of data or space.

Top module: `pfx_engine`

## Requirements
- R1: After reset `busy`, `status`, `nd_in_ready`, `nd_out_valid`, `dma_req` and `cmd_refused` are all 0.
- R2: A start in idle makes `busy` 1 and loads status bits 13:0 with the length. In post-write direction bit 0 of the length is forced to 0.
- R3: A start while busy is refused. `cmd_refused` is 1 for exactly the next cycle, and the running transfer's status is unchanged.
- R4: In prefetch, a byte is taken when `nd_in_valid` and `nd_in_ready` are both high. Each taken byte decrements bits 13:0 by one and raises bits 30:24 (the filled bytes) by one.
- R5: When the FIFO holds 64 bytes in prefetch, `nd_in_ready` is 0 and further NAND bytes are not taken until the host removes data.
- R6: A host read pops 4 bytes, with the earliest fetched byte in `hrd_data[7:0]` and the latest in bits 31:24. A read is ignored when fewer than 4 bytes are held.
- R7: In post-write, a host write is accepted only if at least 2 bytes are free and at least 2 bytes of the length are still unwritten. `hwr_data[7:0]` goes to NAND before `hwr_data[15:8]`, and status bits 30:24 show the free bytes.
- R8: In post-write, bits 13:0 decrement only when a byte leaves on the NAND port. Bits 13:0 therefore reach 0 only after the last byte has been sent.
- R9: With the DMA flag set, `dma_req` is 1 in prefetch while at least 64 bytes are held. In post-write it is 1 while at least 64 bytes are free and at least 64 bytes remain unwritten. With the flag clear it stays 0.
- R10: A reset command empties the FIFO, returns to idle with `status` 0, and wins over a start in the same cycle.
- R11: A start with an effective length of 0 leaves the engine busy with bits 13:0 equal to 0 and no NAND traffic.
- R12: After bits 13:0 reach 0 the engine stays busy until a reset command, and a new start is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse |
| cmd_len | input | 14 | Transfer length in bytes |
| cmd_write | input | 1 | 1 selects post-write, 0 selects prefetch |
| cmd_dma | input | 1 | Enables the frame DMA request |
| cmd_reset | input | 1 | Stops the engine and empties the FIFO |
| cmd_refused | output | 1 | One-cycle pulse for a refused start |
| busy | output | 1 | Engine is not idle |
| status | output | 32 | Bits 30:24 FIFO count, bits 13:0 outstanding bytes, other bits 0 |
| dma_req | output | 1 | Frame DMA request level |
| hrd_req | input | 1 | Host pops one 32-bit word |
| hrd_data | output | 32 | Word at the FIFO head |
| hwr_req | input | 1 | Host pushes one 16-bit word |
| hwr_data | input | 16 | Word to push |
| nd_in_valid | input | 1 | NAND byte available |
| nd_in_data | input | 8 | NAND byte |
| nd_in_ready | output | 1 | Engine takes a NAND byte |
| nd_out_valid | output | 1 | Byte offered to NAND |
| nd_out_data | output | 8 | Byte offered to NAND |
| nd_out_ready | input | 1 | NAND accepts the byte |

## Verification
The bench holds the NAND side back until the FIFO is full. A design that overruns there would take a 65th byte and lower the outstanding count while `nd_in_ready` should be low. It starts a second transfer mid-flight and after completion; a design that restarts would reload the count instead of pulsing `cmd_refused`. In post-write it stalls the NAND port and then releases it, so a design that counts bytes at FIFO entry would show zero outstanding too early. It also pushes writes past the programmed length and reads with fewer than four bytes held; a careless design would send extra bytes or pop garbage.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int LEN_W     = 14;
    localparam int CNT_LSB   = 24;
    localparam int CNT_W     = 7;
    localparam int RD_BYTES  = 4;
    localparam int WR_BYTES  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_POST,
        ST_DONE
    } pfx_state_e;
endpackage

// File: rtl/pfx_fifo.sv
module pfx_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    push_cnt,
    input  logic [15:0]   push_data,
    input  logic [2:0]    pop_cnt,
    output logic [CW-1:0] fill,
    output logic [31:0]   head_word
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_cnt);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            fill   <= fill + CW'(push_cnt) - CW'(pop_cnt);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!clr && (2'(k) < push_cnt))
                mem[wr_ptr + AW'(k)] <= push_data[8*k +: 8];
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign head_word[8*g +: 8] = mem[rd_ptr + AW'(g)];
    end

    // R6: the controller never pops more than is held
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= fill);
    // R5: the controller never pushes past the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill) + int'(push_cnt)) <= DEPTH);
endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
    import pfx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int FRAME = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             wr_sel,
    input  logic             dma_sel,
    input  logic             abort,
    input  logic [CW-1:0]    fill,
    input  logic             nd_in_valid,
    input  logic             nd_out_ready,
    input  logic             hrd_req,
    input  logic             hwr_req,
    output pfx_state_e       state,
    output logic [LEN_W-1:0] remain,
    output logic             mode_wr,
    output logic             nd_in_ready,
    output logic             nd_out_valid,
    output logic [1:0]       push_cnt,
    output logic [2:0]       pop_cnt,
    output logic             start_err,
    output logic             dma_req
);
    pfx_state_e       state_nx;
    logic [LEN_W-1:0] pend;
    logic [LEN_W-1:0] len_eff;
    logic             mode_dma;
    logic [CW-1:0]    space;
    logic             take_nd;
    logic             send_nd;
    logic             host_pop;
    logic             host_push;

    assign len_eff = wr_sel ? {len[LEN_W-1:1], 1'b0} : len;
    assign space   = CW'(DEPTH) - fill;

    // output process
    always_comb begin
        nd_in_ready  = (state == ST_FETCH) && (fill < CW'(DEPTH));
        nd_out_valid = (state == ST_POST) && (fill != '0);
        take_nd      = nd_in_valid && nd_in_ready;
        send_nd      = nd_out_valid && nd_out_ready;
        host_pop     = hrd_req && !mode_wr && (fill >= CW'(RD_BYTES))
                       && ((state == ST_FETCH) || (state == ST_DONE));
        host_push    = hwr_req && (state == ST_POST)
                       && (space >= CW'(WR_BYTES)) && (pend >= LEN_W'(WR_BYTES));
        push_cnt     = take_nd ? 2'd1 : (host_push ? 2'd2 : 2'd0);
        pop_cnt      = host_pop ? 3'd4 : (send_nd ? 3'd1 : 3'd0);
        dma_req      = mode_dma && (
                         (!mode_wr && ((state == ST_FETCH) || (state == ST_DONE))
                          && (fill >= CW'(FRAME)))
                      || ((state == ST_POST) && (space >= CW'(FRAME))
                          && (pend >= LEN_W'(FRAME))));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    state_nx = (len_eff == '0) ? ST_DONE
                             : (wr_sel ? ST_POST : ST_FETCH);
            end
            ST_FETCH: if (take_nd && (remain == LEN_W'(1))) state_nx = ST_DONE;
            ST_POST:  if (send_nd && (remain == LEN_W'(1))) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
        endcase
        if (abort)
            state_nx = ST_IDLE;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remain    <= '0;
            pend      <= '0;
            mode_wr   <= 1'b0;
            mode_dma  <= 1'b0;
            start_err <= 1'b0;
        end else begin
            state     <= state_nx;
            start_err <= start && !abort && (state != ST_IDLE);
            if (abort) begin
                remain <= '0;
                pend   <= '0;
            end else if ((state == ST_IDLE) && start) begin
                remain   <= len_eff;
                pend     <= len_eff;
                mode_wr  <= wr_sel;
                mode_dma <= dma_sel;
            end else begin
                if (take_nd || send_nd)
                    remain <= remain - LEN_W'(1);
                if (host_push)
                    pend <= pend - LEN_W'(WR_BYTES);
            end
        end
    end

    // R3: a refused start keeps the engine busy and flags the refusal
    p_refuse_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && (state != ST_IDLE)) |=> (start_err && (state != ST_IDLE)));
    // R4: outstanding count never grows during a transfer
    p_remain_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !abort) |=> (remain <= $past(remain)));
    // R12: completion is held until a reset command
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DONE) && !abort) |=> (state == ST_DONE));
endmodule

// File: rtl/pfx_engine.sv
module pfx_engine
    import pfx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int FRAME = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [13:0] cmd_len,
    input  logic        cmd_write,
    input  logic        cmd_dma,
    input  logic        cmd_reset,
    output logic        cmd_refused,
    output logic        busy,
    output logic [31:0] status,
    output logic        dma_req,
    input  logic        hrd_req,
    output logic [31:0] hrd_data,
    input  logic        hwr_req,
    input  logic [15:0] hwr_data,
    input  logic        nd_in_valid,
    input  logic [7:0]  nd_in_data,
    output logic        nd_in_ready,
    output logic        nd_out_valid,
    output logic [7:0]  nd_out_data,
    input  logic        nd_out_ready
);
    localparam int CW = $clog2(DEPTH) + 1;

    pfx_state_e       state;
    logic [LEN_W-1:0] remain;
    logic             mode_wr;
    logic [1:0]       push_cnt;
    logic [2:0]       pop_cnt;
    logic [CW-1:0]    fill;
    logic [31:0]      head_word;
    logic [15:0]      push_data;
    logic [CNT_W-1:0] cnt_field;

    pfx_ctrl #(.DEPTH(DEPTH), .FRAME(FRAME)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cmd_start),
        .len          (cmd_len),
        .wr_sel       (cmd_write),
        .dma_sel      (cmd_dma),
        .abort        (cmd_reset),
        .fill         (fill),
        .nd_in_valid  (nd_in_valid),
        .nd_out_ready (nd_out_ready),
        .hrd_req      (hrd_req),
        .hwr_req      (hwr_req),
        .state        (state),
        .remain       (remain),
        .mode_wr      (mode_wr),
        .nd_in_ready  (nd_in_ready),
        .nd_out_valid (nd_out_valid),
        .push_cnt     (push_cnt),
        .pop_cnt      (pop_cnt),
        .start_err    (cmd_refused),
        .dma_req      (dma_req)
    );

    assign push_data = mode_wr ? hwr_data : {8'h00, nd_in_data};

    pfx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_reset),
        .push_cnt  (push_cnt),
        .push_data (push_data),
        .pop_cnt   (pop_cnt),
        .fill      (fill),
        .head_word (head_word)
    );

    always_comb begin
        if (state == ST_IDLE)
            cnt_field = '0;
        else if (mode_wr)
            cnt_field = CNT_W'(CW'(DEPTH) - fill);
        else
            cnt_field = CNT_W'(fill);
        status = '0;
        status[CNT_LSB +: CNT_W] = cnt_field;
        status[LEN_W-1:0]        = remain;
    end

    assign busy        = (state != ST_IDLE);
    assign hrd_data    = head_word;
    assign nd_out_data = head_word[7:0];

    // R5: a full FIFO stalls the NAND input
    p_full_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH)) |-> !nd_in_ready);
    // R8: post-write completes only with an empty FIFO
    p_post_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DONE) && mode_wr) |-> (fill == '0));
    // R10: a reset command clears the engine
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> ((status == 32'h0) && !busy));
endmodule

// File: tb/test_pfx_engine.sv
module test_pfx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_write = 0, cmd_dma = 0, cmd_reset = 0;
    logic [13:0] cmd_len = '0;
    logic        cmd_refused, busy, dma_req;
    logic [31:0] status, hrd_data;
    logic        hrd_req = 0, hwr_req = 0;
    logic [15:0] hwr_data = '0;
    logic        nd_in_valid = 0, nd_in_ready;
    logic [7:0]  nd_in_data = '0, nd_out_data;
    logic        nd_out_valid, nd_out_ready = 0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pfx_engine i_pfx_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_len(cmd_len),
        .cmd_write(cmd_write), .cmd_dma(cmd_dma), .cmd_reset(cmd_reset),
        .cmd_refused(cmd_refused), .busy(busy), .status(status), .dma_req(dma_req),
        .hrd_req(hrd_req), .hrd_data(hrd_data), .hwr_req(hwr_req), .hwr_data(hwr_data),
        .nd_in_valid(nd_in_valid), .nd_in_data(nd_in_data), .nd_in_ready(nd_in_ready),
        .nd_out_valid(nd_out_valid), .nd_out_data(nd_out_data), .nd_out_ready(nd_out_ready)
    );

    // {write, dma, length[13:0], seed[7:0]}
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b0, 14'd4,  8'h10},
        {1'b0, 1'b1, 14'd64, 8'h80},
        {1'b0, 1'b0, 14'd12, 8'hF0},
        {1'b1, 1'b0, 14'd2,  8'h33},
        {1'b1, 1'b1, 14'd64, 8'h01},
        {1'b1, 1'b0, 14'd9,  8'hC8},
        {1'b1, 1'b1, 14'd10, 8'h55}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic wr, input logic dma, input logic [13:0] len);
        @(negedge clk);
        cmd_start = 1; cmd_write = wr; cmd_dma = dma; cmd_len = len;
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic reset_cmd();
        @(negedge clk);
        cmd_reset = 1;
        @(negedge clk);
        cmd_reset = 0;
    endtask

    task automatic feed(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nd_in_valid = 1; nd_in_data = 8'(seed + i);
            while (!nd_in_ready) @(negedge clk);
        end
        @(negedge clk);
        nd_in_valid = 0;
    endtask

    task automatic pop_words(input int n, input logic [7:0] seed, input string req);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            hrd_req = 1;
            chk(req, hrd_data, {8'(seed + 4*w + 3), 8'(seed + 4*w + 2),
                                8'(seed + 4*w + 1), 8'(seed + 4*w)});
        end
        @(negedge clk);
        hrd_req = 0;
    endtask

    task automatic push_words(input int n, input logic [7:0] seed);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            hwr_req = 1; hwr_data = {8'(seed + 2*w + 1), 8'(seed + 2*w)};
        end
        @(negedge clk);
        hwr_req = 0;
    endtask

    task automatic collect(input int n, input logic [7:0] seed, input int total);
        nd_out_ready = 1;
        for (int i = 0; i < n; i++) begin
            chk("R7 byte valid", 32'(nd_out_valid), 32'd1);
            chk("R7 byte order", 32'(nd_out_data), 32'(8'(seed + i)));
            chk("R8 remaining before send", 32'(status[13:0]), 32'(total - i));
            @(negedge clk);
        end
        nd_out_ready = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 status", status, 0);
        chk("R1 nd_in_ready", 32'(nd_in_ready), 0);
        chk("R1 nd_out_valid", 32'(nd_out_valid), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 refused", 32'(cmd_refused), 0);

        for (int v = 0; v < NV; v++) begin
            logic        wr, dma;
            logic [13:0] len, eff;
            logic [7:0]  seed;
            {wr, dma, len, seed} = VEC[v];
            eff = wr ? {len[13:1], 1'b0} : len;
            start_cmd(wr, dma, len);
            chk("R2 busy", 32'(busy), 1);
            chk("R2 length loaded", 32'(status[13:0]), 32'(eff));
            if (!wr) begin
                feed(int'(len), seed);
                chk("R4 fill count", 32'(status[30:24]), 32'(len));
                chk("R4 remaining zero", 32'(status[13:0]), 0);
                chk("R9 dma prefetch", 32'(dma_req), 32'(dma && len >= 64));
                pop_words(int'(len) / 4, seed, "R6 word data");
                chk("R6 drained", 32'(status[30:24]), 0);
                chk("R12 still busy", 32'(busy), 1);
            end else begin
                chk("R9 dma postwrite", 32'(dma_req), 32'(dma && eff >= 64));
                push_words(int'(eff) / 2, seed);
                chk("R7 free count", 32'(status[30:24]), 32'(64 - eff));
                chk("R8 remaining held", 32'(status[13:0]), 32'(eff));
                collect(int'(eff), seed, int'(eff));
                chk("R8 remaining zero", 32'(status[13:0]), 0);
                chk("R12 still busy", 32'(busy), 1);
                chk("R7 free after", 32'(status[30:24]), 64);
            end
            reset_cmd();
            chk("R10 status cleared", status, 0);
        end

        // R3: start while busy
        start_cmd(1'b0, 1'b0, 14'd8);
        feed(2, 8'h40);
        start_cmd(1'b1, 1'b0, 14'd20);
        chk("R3 refused pulse", 32'(cmd_refused), 1);
        chk("R3 remaining kept", 32'(status[13:0]), 6);
        chk("R3 count kept", 32'(status[30:24]), 2);
        @(negedge clk);
        chk("R3 pulse ends", 32'(cmd_refused), 0);
        // R10: reset command wins over start
        @(negedge clk);
        cmd_reset = 1; cmd_start = 1; cmd_write = 0; cmd_len = 14'd5;
        @(negedge clk);
        cmd_reset = 0; cmd_start = 0;
        chk("R10 idle", 32'(busy), 0);
        chk("R10 status", status, 0);
        chk("R10 no refusal", 32'(cmd_refused), 0);

        // R5: full FIFO stalls NAND input
        start_cmd(1'b0, 1'b1, 14'd100);
        feed(64, 8'h00);
        chk("R5 full count", 32'(status[30:24]), 64);
        chk("R5 ready low", 32'(nd_in_ready), 0);
        chk("R9 dma full frame", 32'(dma_req), 1);
        @(negedge clk);
        nd_in_valid = 1; nd_in_data = 8'hEE;
        repeat (3) @(negedge clk);
        nd_in_valid = 0;
        chk("R5 remaining held", 32'(status[13:0]), 36);
        pop_words(1, 8'h00, "R5 head word");
        chk("R5 ready back", 32'(nd_in_ready), 1);
        chk("R5 count after pop", 32'(status[30:24]), 60);
        chk("R9 dma drops", 32'(dma_req), 0);
        reset_cmd();

        // R6: read with fewer than 4 bytes is ignored
        start_cmd(1'b0, 1'b0, 14'd3);
        feed(3, 8'h20);
        @(negedge clk); hrd_req = 1;
        @(negedge clk); hrd_req = 0;
        chk("R6 short read ignored", 32'(status[30:24]), 3);
        reset_cmd();

        // R7: writes past the length are ignored, odd length rounded down
        start_cmd(1'b1, 1'b0, 14'd3);
        chk("R2 rounded length", 32'(status[13:0]), 2);
        push_words(2, 8'hAA);
        chk("R7 extra write ignored", 32'(status[30:24]), 62);
        collect(2, 8'hAA, 2);
        chk("R7 nothing further", 32'(nd_out_valid), 0);
        reset_cmd();

        // R11 zero length, R12 start after completion refused
        start_cmd(1'b0, 1'b0, 14'd0);
        chk("R11 busy", 32'(busy), 1);
        chk("R11 remaining", 32'(status[13:0]), 0);
        chk("R11 no NAND traffic", 32'(nd_in_ready), 0);
        start_cmd(1'b0, 1'b0, 14'd4);
        chk("R12 refused", 32'(cmd_refused), 1);
        chk("R12 remaining", 32'(status[13:0]), 0);
        reset_cmd();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule